// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits behind the asynchronous control pins of an 8-bit parallel flash-style device with an 18-bit address. It samples chip enable, write enable and output enable on the system clock and turns each qualified write strobe into one internal bus cycle. The address of a bus cycle is taken when the strobe opens, and its data when the strobe closes. A small sequencer follows the multi-cycle unlock protocol and emits one-cycle requests. These are byte program (with address and data), sector erase (with sector number) and chip erase. It can also enter or leave an identification mode.

Every command opens with two fixed key writes. No dedicated abort command exists, so any cycle that breaks the expected pattern drops the sequence and puts the decoder back in plain read mode. In identification mode a combinational read path returns the maker code, the device code and the boot-region lock status. The decoder holds off new commands while the array reports busy. It discards programs and erases aimed at the boot region while the lock input is set. The array itself, the operation timing and high-voltage detection live outside the block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus cycle is formed when, after a two-flop synchroniser, chip enable and write enable are both low while output enable is high for at least 2 clocks. The address is captured when this condition opens and the data when it closes. A resulting request pulse is seen 4 clocks after the strobe pins are released.
- R2: A strobe that qualifies for fewer than 2 clocks is ignored. A strobe made while output enable is low is also ignored. Neither one advances or breaks a sequence.
- R3: Key writes 0xAA@0x05555 and 0x55@0x02AAA, then 0xA0@0x05555, then any write make prog_req high for one clock. prog_addr and prog_data carry that write's address and data.
- R4: Keys, 0x80@0x05555, keys, then 0x30 at any address make sec_erase_req high for one clock. sec_num carries address bits 17..9 of that write.
- R5: Keys, 0x80@0x05555, keys, then 0x10@0x05555 make chip_erase_req high for one clock.
- R6: Keys then 0x90@0x05555 set id_mode. While id_mode is set, id_rdata returns values by the two low address bits. Offset 0 returns 0x40. Offset 1 returns 0x02 for a top-boot build or 0xA2 for a bottom-boot build. Offset 2 returns 0x01 when the address lies in the boot region and the lock is set, and 0x00 otherwise. Any other offset returns 0x00. Outside id_mode, id_rdata is 0x00.
- R7: A write of 0xF0 to any address clears id_mode and drops any partial sequence. The only exception is the data cycle of a program.
- R8: A write that does not match the next expected cycle raises no request. It drops the sequence and clears id_mode.
- R9: Bus cycles completed while busy is high are discarded and leave the sequence state unchanged.
- R10: The boot region is the top 16 KB (address bits 17..14 all ones) in the default build. While boot_locked is high, a program or sector erase inside it raises no request, and neither does a chip erase. Addresses outside the boot region are unaffected.
- R11: After reset no request is raised and id_mode is low.
- R12: At most one of the three request outputs is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| addr | input | 18 | Address bus |
| wdata | input | 8 | Write data bus |
| busy | input | 1 | Array operation in progress |
| boot_locked | input | 1 | Boot region lock state |
| prog_req | output | 1 | One-clock byte program request |
| prog_addr | output | 18 | Address to program |
| prog_data | output | 8 | Byte to program |
| sec_erase_req | output | 1 | One-clock sector erase request |
| sec_num | output | 9 | Sector to erase |
| chip_erase_req | output | 1 | One-clock chip erase request |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification read data |

## Verification
Requests and id_mode changes are due exactly 4 clocks after the strobe pins are released. Two of those clocks go to the synchroniser, one to closing the bus cycle and one to the sequencer register. The reference model records each write at its release clock and schedules its expected effect for that clock plus four. The request and mode outputs are compared against the schedule at every falling clock edge, so an early or late pulse is caught as a miscompare. Identification reads are combinational and are checked one time step after the address is set, between writes.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the unlock-sequence command decoder.
// Assumes byte-wide data; key addresses are zero-extended to the address width.
package flash_cmd_pkg;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_TOREAD  = 8'hF0;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_SECTOR  = 8'h30;

    localparam logic [7:0] MAKER_CODE   = 8'h40;
    localparam logic [7:0] DEV_CODE_TOP = 8'h02;
    localparam logic [7:0] DEV_CODE_BOT = 8'hA2;

    typedef enum logic [2:0] {
        SQ_READ,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_ERS1,
        SQ_ERS2,
        SQ_ERS3
    } seq_state_e;

endpackage

// File: rtl/wr_strobe_sync.sv
// Synchronises the asynchronous control pins and forms bus cycles.
// A bus cycle opens when chip and write enable are low with output enable high
// (all after a two-flop synchroniser); the address is taken at that clock.
// It closes when the condition drops; data is taken then and the cycle is
// reported for one clock if it stayed open at least MIN_PULSE clocks.
// Assumes addr is stable while the strobe is open and wdata for two clocks
// after it closes.
module wr_strobe_sync #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic [2:0]       pin_s1;
    logic [2:0]       pin_s2;
    logic             strobe_on;
    logic             strobe_d;
    logic [CNT_W-1:0] width_cnt;

    // Two-flop synchroniser on {ce_n, we_n, oe_n}; idle level is all high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= 3'b111;
            pin_s2 <= 3'b111;
        end else begin
            pin_s1 <= {ce_n, we_n, oe_n};
            pin_s2 <= pin_s1;
        end
    end

    // Write qualification: both enables low, output enable high.
    assign strobe_on = !pin_s2[2] && !pin_s2[1] && pin_s2[0];

    // Track strobe open/close, measure its width and emit the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d  <= 1'b0;
            width_cnt <= '0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            strobe_d <= strobe_on;
            wr_valid <= 1'b0;
            if (strobe_on && !strobe_d) begin
                wr_addr   <= addr;
                width_cnt <= CNT_W'(1);
            end else if (strobe_on) begin
                if (width_cnt < CNT_W'(MIN_PULSE)) begin
                    width_cnt <= width_cnt + CNT_W'(1);
                end
            end else if (strobe_d) begin
                wr_data  <= wdata;
                wr_valid <= (width_cnt >= CNT_W'(MIN_PULSE));
            end
        end
    end

    // R1: a bus cycle lasts exactly one clock.
    p_cycle_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R2: a bus cycle is only reported right after the strobe has closed.
    p_after_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (!strobe_d && $past(strobe_d)));

endmodule

// File: rtl/cmd_sequencer.sv
// Follows the unlock command protocol on completed bus cycles and raises
// one-clock requests. A non-matching cycle returns to read mode (and leaves
// identification mode); cycles arriving while busy are dropped unchanged.
// Assumes wr_valid is a single-clock pulse with address and data held.
module cmd_sequencer
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int SECTOR_BITS = 9,
    parameter int BOOT_BITS   = 14,
    parameter bit BOOT_TOP    = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     busy,
    input  logic                     boot_locked,
    output logic                     prog_req,
    output logic [ADDR_W-1:0]        prog_addr,
    output logic [DATA_W-1:0]        prog_data,
    output logic                     sec_erase_req,
    output logic [ADDR_W-SECTOR_BITS-1:0] sec_num,
    output logic                     chip_erase_req,
    output logic                     id_mode
);

    localparam int SEC_W = ADDR_W - SECTOR_BITS;

    seq_state_e state;
    logic       at_key_a;
    logic       at_key_b;
    logic       wr_in_boot;

    // Boot region test for an address, variant chosen by BOOT_TOP.
    function automatic logic hits_boot(input logic [ADDR_W-1:0] a);
        if (BOOT_TOP) return &a[ADDR_W-1:BOOT_BITS];
        else          return ~|a[ADDR_W-1:BOOT_BITS];
    endfunction

    assign at_key_a   = (wr_addr == ADDR_W'(KEY_ADDR_A));
    assign at_key_b   = (wr_addr == ADDR_W'(KEY_ADDR_B));
    assign wr_in_boot = hits_boot(wr_addr);

    // Sequence state, identification mode and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= SQ_READ;
            id_mode        <= 1'b0;
            prog_req       <= 1'b0;
            prog_addr      <= '0;
            prog_data      <= '0;
            sec_erase_req  <= 1'b0;
            sec_num        <= '0;
            chip_erase_req <= 1'b0;
        end else begin
            prog_req       <= 1'b0;
            sec_erase_req  <= 1'b0;
            chip_erase_req <= 1'b0;
            if (wr_valid && !busy) begin
                state   <= SQ_READ;
                id_mode <= 1'b0;
                unique case (state)
                    SQ_READ: begin
                        if (at_key_a && wr_data == KEY_DATA_A) begin
                            state   <= SQ_KEY1;
                            id_mode <= id_mode;
                        end
                    end
                    SQ_KEY1: begin
                        if (at_key_b && wr_data == KEY_DATA_B) begin
                            state   <= SQ_KEY2;
                            id_mode <= id_mode;
                        end
                    end
                    SQ_KEY2: begin
                        if (at_key_a && wr_data == OP_PROGRAM) begin
                            state   <= SQ_PROG;
                            id_mode <= id_mode;
                        end else if (at_key_a && wr_data == OP_ERASE) begin
                            state   <= SQ_ERS1;
                            id_mode <= id_mode;
                        end else if (at_key_a && wr_data == OP_IDENT) begin
                            id_mode <= 1'b1;
                        end
                    end
                    SQ_PROG: begin
                        if (!(boot_locked && wr_in_boot)) begin
                            prog_req  <= 1'b1;
                            prog_addr <= wr_addr;
                            prog_data <= wr_data;
                        end
                    end
                    SQ_ERS1: begin
                        if (at_key_a && wr_data == KEY_DATA_A) begin
                            state   <= SQ_ERS2;
                            id_mode <= id_mode;
                        end
                    end
                    SQ_ERS2: begin
                        if (at_key_b && wr_data == KEY_DATA_B) begin
                            state   <= SQ_ERS3;
                            id_mode <= id_mode;
                        end
                    end
                    SQ_ERS3: begin
                        if (at_key_a && wr_data == OP_CHIP) begin
                            chip_erase_req <= !boot_locked;
                        end else if (wr_data == OP_SECTOR) begin
                            if (!(boot_locked && wr_in_boot)) begin
                                sec_erase_req <= 1'b1;
                                sec_num       <= wr_addr[ADDR_W-1:SECTOR_BITS];
                            end
                        end
                    end
                    default: state <= SQ_READ;
                endcase
            end
        end
    end

    // R12: never more than one request in a clock.
    p_one_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, sec_erase_req, chip_erase_req}));

    // R9: no request follows a bus cycle taken while busy.
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || sec_erase_req || chip_erase_req) |-> !$past(busy));

    // R10: a program never targets the locked boot region.
    p_lock_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !($past(boot_locked) && hits_boot(prog_addr)));

    // R10: chip erase never issues while locked.
    p_lock_chip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_req |-> !$past(boot_locked));

    // R3: requests come only from a completed bus cycle.
    p_req_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || sec_erase_req || chip_erase_req) |-> $past(wr_valid));

    // R4: sector number keeps its width relation to the address.
    initial begin
        assert (SEC_W > 0);
    end

endmodule

// File: rtl/id_reader.sv
// Combinational identification read path. Returns maker code, device code
// (variant chosen by BOOT_TOP) and boot lock status by the low address bits.
// Assumes id_mode comes from the sequencer; returns zero outside the mode.
module id_reader
    import flash_cmd_pkg::*;
#(
    parameter int HI_W     = 4,
    parameter bit BOOT_TOP = 1'b1
) (
    input  logic            id_mode,
    input  logic            boot_locked,
    input  logic [1:0]      addr_lo,
    input  logic [HI_W-1:0] addr_hi,
    output logic [7:0]      id_rdata
);

    logic       in_boot;
    logic [7:0] dev_code;

    // Select boot placement and device code for this build.
    generate
        if (BOOT_TOP) begin : g_top
            assign in_boot  = &addr_hi;
            assign dev_code = DEV_CODE_TOP;
        end else begin : g_bottom
            assign in_boot  = ~|addr_hi;
            assign dev_code = DEV_CODE_BOT;
        end
    endgenerate

    // Decode the identification offset into read data.
    always_comb begin
        id_rdata = 8'h00;
        if (id_mode) begin
            unique case (addr_lo)
                2'd0:    id_rdata = MAKER_CODE;
                2'd1:    id_rdata = dev_code;
                2'd2:    id_rdata = {7'd0, in_boot && boot_locked};
                default: id_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the unlock-sequence command decoder: strobe synchroniser, command
// sequencer and identification read path.
// Assumes the array drives busy and holds the lock state on boot_locked.
module flash_cmd_decoder #(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 8,
    parameter int SECTOR_BITS = 9,
    parameter int BOOT_BITS   = 14,
    parameter bit BOOT_TOP    = 1'b1,
    parameter int MIN_PULSE   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce_n,
    input  logic                          we_n,
    input  logic                          oe_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          busy,
    input  logic                          boot_locked,
    output logic                          prog_req,
    output logic [ADDR_W-1:0]             prog_addr,
    output logic [DATA_W-1:0]             prog_data,
    output logic                          sec_erase_req,
    output logic [ADDR_W-SECTOR_BITS-1:0] sec_num,
    output logic                          chip_erase_req,
    output logic                          id_mode,
    output logic [7:0]                    id_rdata
);

    localparam int HI_W = ADDR_W - BOOT_BITS;

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    wr_strobe_sync #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MIN_PULSE (MIN_PULSE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    cmd_sequencer #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SECTOR_BITS (SECTOR_BITS),
        .BOOT_BITS   (BOOT_BITS),
        .BOOT_TOP    (BOOT_TOP)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .busy           (busy),
        .boot_locked    (boot_locked),
        .prog_req       (prog_req),
        .prog_addr      (prog_addr),
        .prog_data      (prog_data),
        .sec_erase_req  (sec_erase_req),
        .sec_num        (sec_num),
        .chip_erase_req (chip_erase_req),
        .id_mode        (id_mode)
    );

    id_reader #(
        .HI_W     (HI_W),
        .BOOT_TOP (BOOT_TOP)
    ) u_id (
        .id_mode     (id_mode),
        .boot_locked (boot_locked),
        .addr_lo     (addr[1:0]),
        .addr_hi     (addr[ADDR_W-1:BOOT_BITS]),
        .id_rdata    (id_rdata)
    );

    // R6: identification data stays zero outside identification mode.
    p_id_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> (id_rdata == 8'h00));

    // R11: the first clock after reset carries no request.
    p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !(prog_req || sec_erase_req || chip_erase_req));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
// Bench for the command decoder: a behavioural model schedules each write's
// effect four clocks after strobe release and is compared every clock.
module sim_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy = 1'b0, boot_locked = 1'b0;
    logic        prog_req, sec_erase_req, chip_erase_req, id_mode;
    logic [17:0] prog_addr;
    logic [7:0]  prog_data, id_rdata;
    logic [8:0]  sec_num;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .busy(busy), .boot_locked(boot_locked),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .sec_erase_req(sec_erase_req), .sec_num(sec_num),
        .chip_erase_req(chip_erase_req), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    vectors = 0;
    int    errors  = 0;
    bit    finished = 0;
    string cur_tag = "R11";

    // Reference model state.
    int          mstep = 0;
    bit          mid = 0;
    bit          m_id_out = 0;
    bit          pend = 0;
    int          pdue = 0;
    bit          p_prog, p_sec, p_chip, p_id;
    logic [17:0] p_addr;
    logic [7:0]  p_data;
    logic [8:0]  p_secn;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic bit in_boot(logic [17:0] a);
        return a[17:14] == 4'hF;
    endfunction

    // Model one accepted write, scheduling its outcome.
    task automatic model_write(logic [17:0] a, logic [7:0] d);
        bit ka, kb, lock_hit;
        ka = (a == 18'h05555);
        kb = (a == 18'h02AAA);
        lock_hit = boot_locked && in_boot(a);
        p_prog = 0; p_sec = 0; p_chip = 0;
        if (!busy) begin
            case (mstep)
                0: if (ka && d == 8'hAA) mstep = 1; else begin mstep = 0; mid = 0; end
                1: if (kb && d == 8'h55) mstep = 2; else begin mstep = 0; mid = 0; end
                2: begin
                    if (ka && d == 8'hA0)      mstep = 3;
                    else if (ka && d == 8'h80) mstep = 4;
                    else if (ka && d == 8'h90) begin mstep = 0; mid = 1; end
                    else begin mstep = 0; mid = 0; end
                end
                3: begin
                    mstep = 0; mid = 0;
                    if (!lock_hit) begin p_prog = 1; p_addr = a; p_data = d; end
                end
                4: if (ka && d == 8'hAA) mstep = 5; else begin mstep = 0; mid = 0; end
                5: if (kb && d == 8'h55) mstep = 6; else begin mstep = 0; mid = 0; end
                default: begin
                    mstep = 0; mid = 0;
                    if (ka && d == 8'h10) p_chip = !boot_locked;
                    else if (d == 8'h30 && !lock_hit) begin p_sec = 1; p_secn = a[17:9]; end
                end
            endcase
        end
        p_id = mid;
        pend = 1;
        pdue = cyc + 4;
    endtask

    // Compare every clock against the scheduled model outcome.
    always @(negedge clk) begin
        bit e_prog, e_sec, e_chip;
        if (!finished) begin
            e_prog = 0; e_sec = 0; e_chip = 0;
            if (pend && cyc == pdue) begin
                e_prog = p_prog; e_sec = p_sec; e_chip = p_chip;
                m_id_out = p_id;
                pend = 0;
            end
            chk({cur_tag, " prog_req"}, 32'(prog_req), 32'(e_prog));
            chk({cur_tag, " sec_erase_req"}, 32'(sec_erase_req), 32'(e_sec));
            chk({cur_tag, " chip_erase_req"}, 32'(chip_erase_req), 32'(e_chip));
            chk({cur_tag, " id_mode"}, 32'(id_mode), 32'(m_id_out));
            if (e_prog) begin
                chk({cur_tag, " prog_addr"}, 32'(prog_addr), 32'(p_addr));
                chk({cur_tag, " prog_data"}, 32'(prog_data), 32'(p_data));
            end
            if (e_sec) chk({cur_tag, " sec_num"}, 32'(sec_num), 32'(p_secn));
        end
    end

    // Drive one write strobe of w clocks; optionally with output enable low.
    task automatic bus_write(logic [17:0] a, logic [7:0] d, int w = 3, bit oe_low = 0);
        @(negedge clk);
        addr = a; wdata = d; oe_n = !oe_low; ce_n = 0; we_n = 0;
        repeat (w) @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
        if (w >= 2 && !oe_low) model_write(a, d);
        repeat (6) @(negedge clk);
    endtask

    task automatic keys();
        bus_write(18'h05555, 8'hAA);
        bus_write(18'h02AAA, 8'h55);
    endtask

    task automatic do_program(logic [17:0] a, logic [7:0] d);
        keys(); bus_write(18'h05555, 8'hA0); bus_write(a, d);
    endtask

    task automatic do_erase(logic [17:0] a, logic [7:0] d);
        keys(); bus_write(18'h05555, 8'h80); keys(); bus_write(a, d);
    endtask

    task automatic id_read(logic [17:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, 32'(id_rdata), 32'(exp));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk("R11 reset prog_req", 32'(prog_req), 32'd0);
        chk("R11 reset id_mode", 32'(id_mode), 32'd0);
        chk("R11 reset id_rdata", 32'(id_rdata), 32'd0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        cur_tag = "R3";
        do_program(18'h01234, 8'h5A);
        do_program(18'h3FFFF, 8'h00);

        cur_tag = "R4";
        do_erase(18'h10200, 8'h30);
        do_erase(18'h001FF, 8'h30);

        cur_tag = "R5";
        do_erase(18'h05555, 8'h10);

        cur_tag = "R6";
        keys(); bus_write(18'h05555, 8'h90);
        id_read(18'h12340, 8'h40, "R6 maker");
        id_read(18'h00001, 8'h02, "R6 device");
        id_read(18'h3C002, 8'h00, "R6 lock clear");
        boot_locked = 1;
        id_read(18'h3C002, 8'h01, "R6 lock set");
        id_read(18'h00002, 8'h00, "R6 lock outside boot");
        id_read(18'h00003, 8'h00, "R6 offset three");
        boot_locked = 0;

        cur_tag = "R7";
        bus_write(18'h12345, 8'hF0);
        id_read(18'h00000, 8'h00, "R7 id after exit");
        keys(); bus_write(18'h05555, 8'h80); bus_write(18'h05555, 8'hF0);
        bus_write(18'h05555, 8'h10);

        cur_tag = "R8";
        keys(); bus_write(18'h05555, 8'hFF); bus_write(18'h00100, 8'h11);
        bus_write(18'h05555, 8'hAA); bus_write(18'h02AAB, 8'h55);
        bus_write(18'h05555, 8'hA0); bus_write(18'h00100, 8'h22);
        keys(); bus_write(18'h05555, 8'h90);
        bus_write(18'h00000, 8'h77);
        id_read(18'h00000, 8'h00, "R8 id cleared by mismatch");

        cur_tag = "R2";
        keys(); bus_write(18'h05555, 8'hA0);
        bus_write(18'h00200, 8'h33, 1);
        bus_write(18'h00300, 8'h44, 3, 1);
        bus_write(18'h00400, 8'h55, 2);

        cur_tag = "R9";
        busy = 1;
        do_program(18'h00500, 8'h66);
        busy = 0;
        keys();
        busy = 1;
        bus_write(18'h05555, 8'hA0);
        busy = 0;
        bus_write(18'h05555, 8'hA0);
        bus_write(18'h00600, 8'h99);

        cur_tag = "R10";
        boot_locked = 1;
        do_program(18'h3C100, 8'h12);
        do_program(18'h3BFFF, 8'h34);
        do_erase(18'h3C000, 8'h30);
        do_erase(18'h3BE00, 8'h30);
        do_erase(18'h05555, 8'h10);
        boot_locked = 0;

        cur_tag = "R12";
        repeat (8) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule